// File: doc/BRIEF.md
# MDIO Management Master with Single Control Word

This block runs clause-22 management transactions on an MDC/MDIO pair. Software controls it through one 32-bit control and status word. A single write of that word supplies everything a transaction needs: the target PHY address, the PHY register number, the direction, the 16-bit write data, an enable bit and a launch bit. The block then shifts a complete management frame out on MDIO. MDC is derived from the system clock by an even divide ratio.

During a read, the master releases the data pin from the turnaround onward. It captures the sixteen bits that the PHY returns. When the frame ends it clears the launch bit, which serves as busy, and leaves the received halfword in the low data field of the same word. Software launches a transaction and then polls busy until it reads zero. A launch request that names a PHY address above the supported range does not start a frame, and neither does one that leaves the enable bit clear.

Top module: `mdio_ctl_master`

## Requirements
- R1: While reset is asserted, `rd_data` reads all zeros, `mdc` is low and `mdio_oe` is low.
- R2: The control word has these fields. Bits [15:0] hold the data. Bits [20:16] hold the register number and bits [25:21] the PHY address. Bit 27 is the direction (1 = read, 0 = write), bit 30 is enable and bit 31 is busy. Bits 29, 28 and 26 always read zero. A write accepted while idle stores every field as written.
- R3: A write with bits 31 and 30 both set and a valid PHY address starts a frame. Busy then reads 1 for exactly 64 × `CLK_DIV` clock cycles, beginning in the cycle after the write, and returns to 0 when the frame ends.
- R4: While a frame is in progress, each MDC period lasts `CLK_DIV` clocks: low for the first half and high for the second half. MDC stays low when no frame is in progress.
- R5: The frame is sent MSB first, one bit per MDC period, in this order: 32 ones, then 01, then the opcode (10 for a read, 01 for a write), then the 5-bit PHY address, then the 5-bit register number, then the turnaround (10 on a write), then the 16 data bits. MDIO changes only while MDC is low.
- R6: On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. `mdio_i` is sampled on each rising MDC edge of the 16 data bits. When busy clears, bits [15:0] hold the sampled value, first sample in bit 15.
- R7: A write with busy set and enable clear starts no frame. Busy reads 0 and MDC stays low.
- R8: Only PHY addresses 0 to `PHY_LAST` are valid. A launch request to a higher address starts no frame and busy reads 0.
- R9: A write that arrives while busy is 1 is ignored. The running frame and all stored fields are unchanged.
- R10: `mdio_oe` is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value to write |
| rd_data | output | 32 | Current control and status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = master drives) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check on every cycle that:
- MDC is low while idle and MDIO moves only while MDC is low;
- a frame can begin only with enable set and an address in range;
- the stored fields stay frozen while busy;
- busy clears only after the last bit period;
- the pin is released on every rising MDC edge of a read's turnaround and data phase.

Only the bench's scenarios can show the exact frame bit sequence, the busy length in clocks, the sampled read value landing in the data field, and the rejection of disabled or out-of-range requests. It shows them by comparing the outputs on every clock against a behavioural model.

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master #(
  parameter int CLK_DIV  = 8,
  parameter int PHY_LAST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
  localparam logic [CW-1:0] LAST_AT = CW'(CLK_DIV - 1);
  localparam logic [4:0]    PHY_MAX = 5'(PHY_LAST);

  logic          busy_q, en_q, rd_q, mdc_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   data_q, rx_q;
  logic [63:0]   sh_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]    bit_q;

  wire accept  = wr_en && !busy_q;
  wire launch  = accept && wr_data[31] && wr_data[30] && (wr_data[25:21] <= PHY_MAX);
  wire rise    = busy_q && (cnt_q == RISE_AT);
  wire bit_end = busy_q && (cnt_q == LAST_AT);
  wire done    = bit_end && (bit_q == 6'd63);
  wire rx_zone = rd_q && (bit_q >= 6'd46);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      rd_q   <= 1'b0;
      mdc_q  <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      rx_q   <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (accept) begin
      busy_q <= launch;
      en_q   <= wr_data[30];
      rd_q   <= wr_data[27];
      phy_q  <= wr_data[25:21];
      reg_q  <= wr_data[20:16];
      data_q <= wr_data[15:0];
      rx_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= '0;
      mdc_q  <= 1'b0;
      sh_q   <= {32'hFFFF_FFFF, 2'b01, (wr_data[27] ? 2'b10 : 2'b01),
                 wr_data[25:21], wr_data[20:16], 2'b10, wr_data[15:0]};
    end else if (busy_q) begin
      if (rise) begin
        mdc_q <= 1'b1;
        if (rd_q && bit_q >= 6'd48) rx_q <= {rx_q[14:0], mdio_i};
      end
      if (bit_end) begin
        mdc_q <= 1'b0;
        cnt_q <= '0;
        if (done) begin
          busy_q <= 1'b0;
          if (rd_q) data_q <= rx_q;
        end else begin
          bit_q <= bit_q + 6'd1;
          sh_q  <= {sh_q[62:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = busy_q & sh_q[63];
  assign mdio_oe = busy_q & ~rx_zone;
  assign rd_data = {busy_q, en_q, 2'b00, rd_q, 1'b0, phy_q, reg_q, data_q};

  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);

  a_r10_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !mdc && !mdio_oe);

  a_r8_phy_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> phy_q <= PHY_MAX);

  a_r7_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> en_q);

  a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(phy_q) && $stable(reg_q) && $stable(rd_q) && $stable(en_q));

  a_r3_ends_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bit_q) == 6'd63 && $past(cnt_q) == LAST_AT);

  a_r5_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> !mdc);

  a_r6_released_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc) && rd_q && bit_q >= 6'd46) |-> !mdio_oe);
endmodule

// File: tb/mdio_ctl_master_test.sv
module mdio_ctl_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int PL   = 4;
  localparam int FLEN = 64 * DIV;

  logic        clk, rst_n, wr_en, mdio_i;
  logic [31:0] wr_data, rd_data;
  logic        mdc, mdio_o, mdio_oe;

  mdio_ctl_master #(.CLK_DIV(DIV), .PHY_LAST(PL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int tests = 0;
  int fails = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        m_act, m_en, m_rd;
  logic [4:0]  m_phy, m_reg;
  logic [15:0] m_data, phy_val;
  logic [63:0] m_frame;
  int          m_k;
  int          b;
  logic        e_mdc, e_oe;

  function automatic logic [31:0] cw(logic bz, logic en, logic rd,
                                     logic [4:0] p, logic [4:0] g, logic [15:0] d);
    return {bz, en, 2'b00, rd, 1'b0, p, g, d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_en <= 0; m_rd <= 0; m_phy <= 0; m_reg <= 0;
      m_data <= 0; m_k <= 0; m_frame <= 0;
    end else if (m_act) begin
      if (m_k == FLEN - 1) begin
        m_act <= 0;
        if (m_rd) m_data <= phy_val;
      end else m_k <= m_k + 1;
    end else if (wr_en) begin
      m_en   <= wr_data[30];
      m_rd   <= wr_data[27];
      m_phy  <= wr_data[25:21];
      m_reg  <= wr_data[20:16];
      m_data <= wr_data[15:0];
      m_k    <= 0;
      m_act  <= wr_data[31] && wr_data[30] && (int'(wr_data[25:21]) <= PL);
      m_frame <= {{32{1'b1}}, 2'b01, wr_data[27] ? 2'b10 : 2'b01,
                  wr_data[25:21], wr_data[20:16], 2'b10, wr_data[15:0]};
    end
  end

  always @(negedge clk) begin
    b = m_k / DIV;
    e_mdc = m_act && ((m_k % DIV) >= DIV / 2);
    e_oe  = m_act && !(m_rd && b >= 46);
    chk("R2 R3 R9 word", rd_data, {m_act, m_en, 2'b00, m_rd, 1'b0, m_phy, m_reg, m_data});
    chk("R4 mdc", {31'b0, mdc}, {31'b0, e_mdc});
    chk("R6 R10 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
    if (e_oe) chk("R5 mdio bit", {31'b0, mdio_o}, {31'b0, m_frame[63 - b]});
    mdio_i = (m_act && m_rd && b >= 48) ? phy_val[63 - b] : 1'b1;
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_idle;
    while (m_act) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mdio_i = 1'b1; phy_val = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset pins", {30'b0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;

    wr(cw(0, 1, 0, 5'd3, 5'd7, 16'hBEEF));
    chk("R2 fields stored", rd_data, cw(0, 1, 0, 5'd3, 5'd7, 16'hBEEF));
    wr(32'h7FFF_FFFF);
    chk("R2 reserved bits zero", rd_data, 32'h4BFF_FFFF);

    wr(cw(1, 1, 0, 5'd2, 5'h1F, 16'hA5C3));
    n = 0;
    while (rd_data[31] && n < FLEN + 10) begin n++; @(negedge clk); end
    chk("R3 busy length", n, FLEN);
    wait_idle();
    chk("R3 write done", rd_data, cw(0, 1, 0, 5'd2, 5'h1F, 16'hA5C3));

    phy_val = 16'h1234;
    wr(cw(1, 1, 1, 5'd4, 5'd2, 16'h0000));
    chk("R8 highest valid phy launches", {31'b0, rd_data[31]}, 32'h1);
    wait_idle();
    chk("R6 read data", rd_data, cw(0, 1, 1, 5'd4, 5'd2, 16'h1234));

    phy_val = 16'h8001;
    wr(cw(1, 1, 1, 5'd0, 5'h11, 16'hFFFF));
    wait_idle();
    chk("R6 read data edges", rd_data, cw(0, 1, 1, 5'd0, 5'h11, 16'h8001));

    wr(cw(1, 0, 0, 5'd1, 5'd1, 16'h0F0F));
    repeat (2 * DIV) @(negedge clk);
    chk("R7 no launch without enable", rd_data, cw(0, 0, 0, 5'd1, 5'd1, 16'h0F0F));
    chk("R7 mdc quiet", {31'b0, mdc}, 32'h0);

    wr(cw(1, 1, 1, 5'd5, 5'd3, 16'h0000));
    repeat (2 * DIV) @(negedge clk);
    chk("R8 phy 5 rejected", rd_data, cw(0, 1, 1, 5'd5, 5'd3, 16'h0000));
    wr(cw(1, 1, 0, 5'd31, 5'd3, 16'h00AA));
    repeat (2 * DIV) @(negedge clk);
    chk("R8 phy 31 rejected", rd_data, cw(0, 1, 0, 5'd31, 5'd3, 16'h00AA));
    chk("R10 released when idle", {31'b0, mdio_oe}, 32'h0);

    wr(cw(1, 1, 0, 5'd1, 5'd2, 16'h1111));
    repeat (10) @(negedge clk);
    wr(cw(1, 1, 1, 5'd3, 5'd4, 16'h2222));
    chk("R9 write while busy ignored", rd_data, cw(1, 1, 0, 5'd1, 5'd2, 16'h1111));
    wait_idle();
    chk("R9 frame unaffected", rd_data, cw(0, 1, 0, 5'd1, 5'd2, 16'h1111));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule